// File: doc/BRIEF.md
# Processor Power-Mode Entry Sequencer

This block controls how a processor core enters and leaves its low-power states. Configuration software first picks one of three low-power modes (light, medium, deep) by writing a mode bit into a 32-bit mode-configuration word. Later, the machine-state logic pulses a power-request input, and only then does the sequencer act. The light mode stops the core clock at once but keeps the snoop clock running. The medium and deep modes first ask the bus interface to quiesce. They wait until the bus reports idle, and then they gate every core clock.

A wake event returns the core to running. A wake event is the system-management interrupt line, or the external interrupt line when the interrupt-enable input is set. Leaving the deep mode passes through a relock phase. During that phase the clocks stay gated for a parameterised number of cycles, so the clock synthesiser can settle. Every wake clears the pending power request, so the core does not fall straight back asleep. A wake that arrives while the bus is still draining cancels the entry.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset the state code is RUN (0), the core and snoop clock enables are 1, the quiesce request is 0, the power request is 0 and the configuration word is 0.
- R2: A configuration write replaces the whole 32-bit word on the next edge. Bit 23 selects light mode, bit 22 medium mode, bit 21 deep mode, and bit 20 drives the dynamic-power enable output.
- R3: A power request seen while no mode bit (23..21) is set causes no entry. The state stays RUN and the request bit is cleared one edge after it was seen.
- R4: When several mode bits are set, deep takes priority over medium, and medium takes priority over light.
- R5: Light mode goes straight from RUN to DOZE without draining. In DOZE the core clock enable is 0, the snoop clock enable is 1 and the quiesce request is 0.
- R6: Medium and deep modes first enter DRAIN, where the quiesce request is 1 and both clocks stay enabled. The sequencer leaves DRAIN for a gated state only on an edge where bus-idle is 1.
- R7: In NAP, SLEEP and RELOCK both clock enables are 0 and the quiesce request is 1.
- R8: The wake condition is smInt OR (extInt AND extIntEn). When extIntEn is 0, extInt has no effect.
- R9: A wake during DRAIN returns the sequencer to RUN on the next edge, without passing through a gated state.
- R10: A wake in SLEEP moves to RELOCK. The sequencer stays in RELOCK for exactly RELOCK_CYCLES cycles and then returns to RUN. A wake in DOZE or NAP returns directly to RUN.
- R11: Every wake exit clears the power request on the same edge, unless a new request pulse arrives on that edge. A new pulse takes priority.
- R12: The state codes are RUN=0, DRAIN=1, DOZE=2, NAP=3, SLEEP=4, RELOCK=5. A power request in RUN is acted on one edge after the request bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Write strobe for the mode-configuration word |
| cfgWrData | input | 32 | New mode-configuration word |
| modeCfg | output | 32 | Current mode-configuration word |
| dpmEnable | output | 1 | Dynamic-power enable bit of the configuration word |
| powReqSet | input | 1 | Pulse that sets the power-request bit |
| powReq | output | 1 | Pending power-request bit |
| extIntEn | input | 1 | External interrupt enable |
| extInt | input | 1 | External interrupt wake line |
| smInt | input | 1 | System-management interrupt wake line |
| busIdle | input | 1 | No bus transaction outstanding |
| quiesceReq | output | 1 | Request to the bus interface to stop issuing |
| coreClkEn | output | 1 | Core clock enable |
| snoopClkEn | output | 1 | Bus-snoop clock enable |
| stateCode | output | 3 | Current sequencer state |

## Verification
A request pulse reaches the request bit at the first rising edge. The state moves at the second edge. The clock enables and quiesce request are decoded from the state register, so they change right after that second edge. A wake, a drain completion or a configuration write takes effect at the next edge. A deep-mode exit holds RELOCK for exactly RELOCK_CYCLES samples. The bench drives inputs just after a falling edge and steps its reference model on the rising edge. It compares every output at the following falling edge, so each result is read in the cycle it is due. Directed checks count the relock samples and probe the ignored-request and masked-interrupt cases at the ports.

// File: rtl/pms_pkg.sv
package pms_pkg;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_DRAIN  = 3'd1,
    ST_DOZE   = 3'd2,
    ST_NAP    = 3'd3,
    ST_SLEEP  = 3'd4,
    ST_RELOCK = 3'd5
  } pmsState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrPow;
    logic loadRelock;
    logic decRelock;
  } pmsStrobe_t;

  // conditions from datapath to control
  typedef struct packed {
    logic powReq;
    logic wake;
    logic selSleep;
    logic selNap;
    logic selDoze;
    logic relockDone;
    logic busIdle;
  } pmsStatus_t;

endpackage

// File: rtl/pms_datapath.sv
module pms_datapath
  import pms_pkg::*;
#(
  parameter int CFG_W         = 32,
  parameter int DOZE_BIT      = 23,
  parameter int NAP_BIT       = 22,
  parameter int SLEEP_BIT     = 21,
  parameter int DPM_BIT       = 20,
  parameter int RELOCK_CYCLES = 12500
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic             powReqSet,
  input  logic             extInt,
  input  logic             smInt,
  input  logic             extIntEn,
  input  logic             busIdle,
  input  pmsStrobe_t       strobe,
  output pmsStatus_t       status,
  output logic [CFG_W-1:0] modeCfg,
  output logic             powReq,
  output logic             dpmEnable
);

  localparam int CNT_W = (RELOCK_CYCLES > 1) ? $clog2(RELOCK_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RELOCK_CYCLES - 1);

  logic [CFG_W-1:0] cfgQ;
  logic             powQ;
  logic [CNT_W-1:0] relockCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else if (cfgWrEn) begin
      cfgQ <= cfgWrData;
    end
  end

  // a fresh request pulse wins over the clear from a wake exit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      powQ <= 1'b0;
    end else if (powReqSet) begin
      powQ <= 1'b1;
    end else if (strobe.clrPow) begin
      powQ <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      relockCnt <= '0;
    end else if (strobe.loadRelock) begin
      relockCnt <= CNT_LOAD;
    end else if (strobe.decRelock && relockCnt != '0) begin
      relockCnt <= relockCnt - 1'b1;
    end
  end

  logic wakeNow;
  assign wakeNow = smInt | (extInt & extIntEn);

  always_comb begin
    status            = '0;
    status.powReq     = powQ;
    status.wake       = wakeNow;
    status.selSleep   = cfgQ[SLEEP_BIT];
    status.selNap     = cfgQ[NAP_BIT] & ~cfgQ[SLEEP_BIT];
    status.selDoze    = cfgQ[DOZE_BIT] & ~cfgQ[NAP_BIT] & ~cfgQ[SLEEP_BIT];
    status.relockDone = (relockCnt == '0);
    status.busIdle    = busIdle;
  end

  assign modeCfg   = cfgQ;
  assign powReq    = powQ;
  assign dpmEnable = cfgQ[DPM_BIT];

endmodule

// File: rtl/pms_control.sv
module pms_control
  import pms_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  pmsStatus_t status,
  output pmsStrobe_t strobe,
  output logic [2:0] stateCode,
  output logic       quiesceReq,
  output logic       coreClkEn,
  output logic       snoopClkEn
);

  pmsState_e stQ, stNxt;
  logic      tgtSleepQ;

  always_comb begin
    stNxt  = stQ;
    strobe = '0;
    unique case (stQ)
      ST_RUN: begin
        if (status.powReq) begin
          if (status.selSleep || status.selNap) stNxt = ST_DRAIN;
          else if (status.selDoze)              stNxt = ST_DOZE;
          else                                  strobe.clrPow = 1'b1;
        end
      end
      ST_DRAIN: begin
        if (status.wake) begin
          stNxt         = ST_RUN;
          strobe.clrPow = 1'b1;
        end else if (status.busIdle) begin
          stNxt = tgtSleepQ ? ST_SLEEP : ST_NAP;
        end
      end
      ST_DOZE, ST_NAP: begin
        if (status.wake) begin
          stNxt         = ST_RUN;
          strobe.clrPow = 1'b1;
        end
      end
      ST_SLEEP: begin
        if (status.wake) begin
          stNxt             = ST_RELOCK;
          strobe.clrPow     = 1'b1;
          strobe.loadRelock = 1'b1;
        end
      end
      ST_RELOCK: begin
        if (status.relockDone) stNxt = ST_RUN;
        else                   strobe.decRelock = 1'b1;
      end
      default: stNxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ       <= ST_RUN;
      tgtSleepQ <= 1'b0;
    end else begin
      stQ <= stNxt;
      if (stQ == ST_RUN && stNxt == ST_DRAIN) tgtSleepQ <= status.selSleep;
    end
  end

  always_comb begin
    coreClkEn  = (stQ == ST_RUN) || (stQ == ST_DRAIN);
    snoopClkEn = coreClkEn || (stQ == ST_DOZE);
    quiesceReq = (stQ == ST_DRAIN) || (stQ == ST_NAP) ||
                 (stQ == ST_SLEEP) || (stQ == ST_RELOCK);
  end

  assign stateCode = stQ;

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pms_pkg::*;
#(
  parameter int CFG_W         = 32,
  parameter int DOZE_BIT      = 23,
  parameter int NAP_BIT       = 22,
  parameter int SLEEP_BIT     = 21,
  parameter int DPM_BIT       = 20,
  parameter int RELOCK_CYCLES = 12500
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  output logic [CFG_W-1:0] modeCfg,
  output logic             dpmEnable,
  input  logic             powReqSet,
  output logic             powReq,
  input  logic             extIntEn,
  input  logic             extInt,
  input  logic             smInt,
  input  logic             busIdle,
  output logic             quiesceReq,
  output logic             coreClkEn,
  output logic             snoopClkEn,
  output logic [2:0]       stateCode
);

  pmsStrobe_t strobe;
  pmsStatus_t status;

  pms_datapath #(
    .CFG_W(CFG_W), .DOZE_BIT(DOZE_BIT), .NAP_BIT(NAP_BIT),
    .SLEEP_BIT(SLEEP_BIT), .DPM_BIT(DPM_BIT), .RELOCK_CYCLES(RELOCK_CYCLES)
  ) uDp (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .powReqSet(powReqSet), .extInt(extInt), .smInt(smInt),
    .extIntEn(extIntEn), .busIdle(busIdle), .strobe(strobe),
    .status(status), .modeCfg(modeCfg), .powReq(powReq),
    .dpmEnable(dpmEnable)
  );

  pms_control uCtl (
    .clk(clk), .rstN(rstN), .status(status), .strobe(strobe),
    .stateCode(stateCode), .quiesceReq(quiesceReq),
    .coreClkEn(coreClkEn), .snoopClkEn(snoopClkEn)
  );

endmodule

// File: rtl/pms_checker.sv
module pms_checker (
  input logic       clk,
  input logic       rstN,
  input logic       powReqSet,
  input logic       extIntEn,
  input logic       extInt,
  input logic       smInt,
  input logic       busIdle,
  input logic       powReq,
  input logic       quiesceReq,
  input logic       coreClkEn,
  input logic       snoopClkEn,
  input logic [2:0] stateCode
);

  logic wakeSeen;
  assign wakeSeen = smInt | (extInt & extIntEn);

  // R12 / R1: legal codes, running outputs in RUN
  a_r12_legal_state: assert property (@(posedge clk) disable iff (!rstN)
    stateCode <= 3'd5);
  a_r1_run_outputs: assert property (@(posedge clk) disable iff (!rstN)
    stateCode == 3'd0 |-> coreClkEn && snoopClkEn && !quiesceReq);

  a_r5_doze_outputs: assert property (@(posedge clk) disable iff (!rstN)
    stateCode == 3'd2 |-> !coreClkEn && snoopClkEn && !quiesceReq);

  a_r6_hold_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    stateCode == 3'd1 && !busIdle && !wakeSeen |=> stateCode == 3'd1);

  a_r7_gated: assert property (@(posedge clk) disable iff (!rstN)
    stateCode >= 3'd3 && stateCode <= 3'd5 |-> !coreClkEn && !snoopClkEn && quiesceReq);

  a_r9_drain_abort: assert property (@(posedge clk) disable iff (!rstN)
    stateCode == 3'd1 && wakeSeen |=> stateCode == 3'd0);

  a_r10_sleep_exit: assert property (@(posedge clk) disable iff (!rstN)
    stateCode == 3'd4 && wakeSeen |=> stateCode == 3'd5);

  a_r11_clear_on_wake: assert property (@(posedge clk) disable iff (!rstN)
    stateCode >= 3'd2 && stateCode <= 3'd4 && wakeSeen && !powReqSet |=> !powReq);

endmodule

bind pwr_mode_seq pms_checker uChk (
  .clk(clk), .rstN(rstN), .powReqSet(powReqSet), .extIntEn(extIntEn),
  .extInt(extInt), .smInt(smInt), .busIdle(busIdle), .powReq(powReq),
  .quiesceReq(quiesceReq), .coreClkEn(coreClkEn), .snoopClkEn(snoopClkEn),
  .stateCode(stateCode)
);

// File: tb/sim_pwr_mode_seq.sv
`timescale 1ns/1ps
module sim_pwr_mode_seq;

  localparam int RLK = 20;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] modeCfg;
  logic        dpmEnable;
  logic        powReqSet = 1'b0;
  logic        powReq;
  logic        extIntEn = 1'b0;
  logic        extInt = 1'b0;
  logic        smInt = 1'b0;
  logic        busIdle = 1'b1;
  logic        quiesceReq, coreClkEn, snoopClkEn;
  logic [2:0]  stateCode;

  pwr_mode_seq #(.RELOCK_CYCLES(RLK)) u0 (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .modeCfg(modeCfg), .dpmEnable(dpmEnable), .powReqSet(powReqSet),
    .powReq(powReq), .extIntEn(extIntEn), .extInt(extInt), .smInt(smInt),
    .busIdle(busIdle), .quiesceReq(quiesceReq), .coreClkEn(coreClkEn),
    .snoopClkEn(snoopClkEn), .stateCode(stateCode)
  );

  int checks = 0;
  int errors = 0;

  // reference model, stepped on every rising edge
  logic [2:0]  mSt = 3'd0;
  logic        mPow = 1'b0;
  logic [31:0] mCfg = '0;
  int          mCnt = 0;
  logic        mTgt = 1'b0;
  logic        mWake, mClr;
  logic [2:0]  mNx;

  always @(posedge clk) begin
    if (!rstN) begin
      mSt = 3'd0; mPow = 1'b0; mCfg = '0; mCnt = 0; mTgt = 1'b0;
    end else begin
      mWake = smInt | (extInt & extIntEn);
      mClr  = 1'b0;
      mNx   = mSt;
      case (mSt)
        3'd0: if (mPow) begin
          if (mCfg[21])      begin mNx = 3'd1; mTgt = 1'b1; end
          else if (mCfg[22]) begin mNx = 3'd1; mTgt = 1'b0; end
          else if (mCfg[23]) mNx = 3'd2;
          else               mClr = 1'b1;
        end
        3'd1: if (mWake) begin mNx = 3'd0; mClr = 1'b1; end
              else if (busIdle) mNx = mTgt ? 3'd4 : 3'd3;
        3'd2, 3'd3: if (mWake) begin mNx = 3'd0; mClr = 1'b1; end
        3'd4: if (mWake) begin mNx = 3'd5; mClr = 1'b1; mCnt = RLK - 1; end
        3'd5: if (mCnt == 0) mNx = 3'd0; else mCnt = mCnt - 1;
        default: mNx = 3'd0;
      endcase
      mPow = powReqSet ? 1'b1 : (mClr ? 1'b0 : mPow);
      if (cfgWrEn) mCfg = cfgWrData;
      mSt = mNx;
    end
  end

  function automatic logic [39:0] expVec();
    logic core, snoop, quies;
    core  = (mSt == 3'd0) || (mSt == 3'd1);
    snoop = core || (mSt == 3'd2);
    quies = (mSt == 3'd1) || (mSt == 3'd3) || (mSt == 3'd4) || (mSt == 3'd5);
    return {mSt, core, snoop, quies, mPow, mCfg[20], mCfg};
  endfunction

  function automatic string tagFor(input logic [2:0] s);
    case (s)
      3'd1: return "R6";
      3'd2: return "R5";
      3'd3, 3'd4: return "R7";
      3'd5: return "R10";
      default: return "R12";
    endcase
  endfunction

  task automatic cmpModel(input string tag);
    logic [39:0] got;
    got = {stateCode, coreClkEn, snoopClkEn, quiesceReq, powReq, dpmEnable, modeCfg};
    checks++;
    if (got !== expVec()) begin
      errors++;
      $display("FAIL %s model got=%h exp=%h", tag, got, expVec());
    end
  endtask

  task automatic expectEq(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    @(negedge clk);
    cmpModel(tag);
  endtask

  task automatic writeCfg(input logic [31:0] v);
    cfgWrEn = 1'b1; cfgWrData = v;
    step("R2");
    cfgWrEn = 1'b0;
  endtask

  task automatic pulseReq();
    powReqSet = 1'b1;
    step("R12");
    powReqSet = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R1 watchdog got=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    int unsigned seed;
    int n;
    seed = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step("R1");
    // R1 reset state
    expectEq("R1", {25'd0, stateCode, coreClkEn, snoopClkEn, quiesceReq, powReq},
             {25'd0, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0});
    expectEq("R1", modeCfg, 32'h0);

    // R2 dynamic-power bit and word write
    writeCfg(32'h0010_0000);
    expectEq("R2", {31'd0, dpmEnable}, 32'd1);
    expectEq("R2", modeCfg, 32'h0010_0000);

    // R3 request without mode bit is dropped
    pulseReq();
    expectEq("R3", {31'd0, powReq}, 32'd1);
    step("R3");
    step("R3");
    expectEq("R3", {28'd0, stateCode, powReq}, {28'd0, 3'd0, 1'b0});

    // R4 priority to deep, then R10/R11 exit through relock
    writeCfg(32'h00E0_0000);
    pulseReq();
    step("R6");
    expectEq("R6", {29'd0, stateCode}, 32'd1);
    step("R4");
    expectEq("R4", {29'd0, stateCode}, 32'd4);
    expectEq("R7", {30'd0, coreClkEn, snoopClkEn}, 32'd0);
    repeat (3) step("R7");
    smInt = 1'b1;
    step("R10");
    smInt = 1'b0;
    expectEq("R10", {29'd0, stateCode}, 32'd5);
    expectEq("R11", {31'd0, powReq}, 32'd0);
    n = 1;
    while (stateCode == 3'd5 && n < 1000) begin
      step("R10");
      if (stateCode == 3'd5) n++;
    end
    expectEq("R10", n, RLK);
    expectEq("R10", {28'd0, stateCode, coreClkEn}, {28'd0, 3'd0, 1'b1});

    // R5 light mode, R8 masked external interrupt
    writeCfg(32'h0080_0000);
    pulseReq();
    step("R5");
    expectEq("R5", {28'd0, stateCode, coreClkEn}, {28'd0, 3'd2, 1'b0});
    expectEq("R5", {30'd0, snoopClkEn, quiesceReq}, {30'd0, 1'b1, 1'b0});
    extInt = 1'b1; extIntEn = 1'b0;
    repeat (4) step("R8");
    expectEq("R8", {29'd0, stateCode}, 32'd2);
    extIntEn = 1'b1;
    step("R8");
    expectEq("R8", {28'd0, stateCode, powReq}, {28'd0, 3'd0, 1'b0});
    extInt = 1'b0; extIntEn = 1'b0;

    // R6 drain holds while bus busy, R9 abort
    writeCfg(32'h0040_0000);
    busIdle = 1'b0;
    pulseReq();
    step("R6");
    repeat (3) step("R6");
    expectEq("R6", {28'd0, stateCode, quiesceReq}, {28'd0, 3'd1, 1'b1});
    expectEq("R6", {31'd0, coreClkEn}, 32'd1);
    smInt = 1'b1;
    step("R9");
    smInt = 1'b0;
    expectEq("R9", {28'd0, stateCode, powReq}, {28'd0, 3'd0, 1'b0});

    // R7 medium mode after drain completes
    pulseReq();
    step("R6");
    busIdle = 1'b1;
    step("R7");
    expectEq("R7", {27'd0, stateCode, coreClkEn, snoopClkEn}, {27'd0, 3'd3, 1'b0, 1'b0});
    extIntEn = 1'b1; extInt = 1'b1;
    step("R10");
    expectEq("R10", {29'd0, stateCode}, 32'd0);
    extInt = 1'b0; extIntEn = 1'b0;

    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      cfgWrEn   = ($urandom_range(99) < 3);
      cfgWrData = {8'h00, 4'($urandom_range(15)), 20'h0};
      powReqSet = ($urandom_range(99) < 8);
      smInt     = ($urandom_range(99) < 2);
      extInt    = ($urandom_range(99) < 4);
      extIntEn  = $urandom_range(1);
      busIdle   = ($urandom_range(99) < 75);
      step(tagFor(mSt));
    end
    cfgWrEn = 1'b0; powReqSet = 1'b0; smInt = 1'b0; extInt = 1'b0;

    summary();
    $finish;
  end

endmodule